// File: doc/BRIEF.md
# Dual Non-Retriggerable Pulse Generator

This block holds two independent one-shot channels. Each channel turns a trigger event into a single output pulse whose length is a programmed number of clock cycles. Each channel has two trigger inputs of opposite edge polarity: a falling-edge input and a rising-edge input. Each trigger input also gates the other, so holding one input at its blocking level inhibits the other. An active-low clear ends a running pulse at once and keeps the outputs idle while it is held low.

Releasing the clear can fire a pulse by itself when both trigger inputs sit at their enabling levels. This only happens if a per-channel arming flag was set beforehand. The flag is set while the clear is inactive and either trigger input is at its blocking level. Firing from clear release uses up the flag.

All trigger and clear inputs pass through a synchronizer first, and every edge is detected on the synchronized values. Once a pulse is running, the channel ignores its trigger inputs until the pulse ends. Each channel drives a true output and a complementary output.

Top module: `dual_oneshot`

## Requirements
- R1: While `rst_n` is low, and afterwards until a trigger, every `pulse_o` bit is 0 and every `pulse_n_o` bit is 1.
- R2: A 1-to-0 change on `fall_trig_i[i]` while `rise_trig_i[i]` and `clr_n_i[i]` are 1 fires a pulse on channel i. `pulse_o[i]` rises after the third rising clock edge that follows the input change.
- R3: A 0-to-1 change on `rise_trig_i[i]` while `fall_trig_i[i]` is 0 and `clr_n_i[i]` is 1 fires a pulse on channel i, with the same latency as in R2.
- R4: A 1 held on `fall_trig_i[i]` blocks firing from `rise_trig_i[i]`. A 0 held on `rise_trig_i[i]` blocks firing from `fall_trig_i[i]`.
- R5: While the synchronized `clr_n_i[i]` is 0, `pulse_o[i]` is 0. A running pulse is ended by it and does not resume when the clear is released.
- R6: While a pulse runs, edges on `fall_trig_i[i]` and `rise_trig_i[i]` neither restart it nor lengthen it.
- R7: A 0-to-1 change on `clr_n_i[i]` with `fall_trig_i[i]`=0 and `rise_trig_i[i]`=1 fires a pulse only if the arming flag is set. The flag is set only in cycles where the clear is 1 and either `fall_trig_i[i]`=1 or `rise_trig_i[i]`=0.
- R8: A pulse fired by clear release clears the arming flag. A second clear cycle with no blocking-level input in between fires nothing.
- R9: Pulse length in cycles is max(W,1), where W is the unsigned value of `width_i[i*CW +: CW]` sampled in the cycle the pulse starts. Later changes to W do not affect the running pulse.
- R10: `pulse_n_o[i]` is always the inverse of `pulse_o[i]`.
- R11: The channels are independent: triggers, clears and widths on one channel never change the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fall_trig_i | input | NCH | Falling-edge trigger per channel; high level inhibits the rising trigger |
| rise_trig_i | input | NCH | Rising-edge trigger per channel; low level inhibits the falling trigger |
| clr_n_i | input | NCH | Active-low clear per channel |
| width_i | input | NCH*CW | Pulse length per channel, channel i at bits i*CW +: CW |
| pulse_o | output | NCH | True pulse output per channel |
| pulse_n_o | output | NCH | Complementary pulse output per channel |

## Verification
The bench builds the block with two channels, a 16-bit width field and a two-stage synchronizer. This makes the three-cycle trigger latency, the cross-channel isolation and the full arming-flag sequence observable. Widths stay small (0, 1, 3 to 20), so the max(W,1) floor and the mid-pulse width change are reached within a few cycles. The reference model counts down the loaded width and checks it against the outputs on every cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Synchronized view of one channel's control inputs.
  //   fl : falling-edge trigger level
  //   rs : rising-edge trigger level
  //   cn : active-low clear level
  typedef struct packed {
    logic fl;
    logic rs;
    logic cn;
  } trig_t;

  // Level seen before real inputs arrive: both triggers at blocking levels, clear active.
  localparam trig_t TRIG_SAFE = '{fl: 1'b1, rs: 1'b0, cn: 1'b0};
endpackage

// File: rtl/os_sync.sv
module os_sync
  import oneshot_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  trig_t d_i,
  output trig_t q_o
);
  trig_t stg_q [STAGES];
  trig_t stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stg_d[g] = d_i;
    end else begin : g_next
      always_comb stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= TRIG_SAFE;
      else        stg_q[g] <= stg_d[g];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/os_qual.sv
module os_qual
  import oneshot_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  trig_t s_i,
  input  logic  busy_i,
  output logic  fire_o,
  output logic  fire_clr_o,
  output logic  cond_o
);
  // Edges are trusted only once the synchronizer and previous-value stage hold real samples.
  localparam int WARM = STAGES + 1;

  trig_t           prev_q;
  logic [WARM-1:0] warm_q, warm_d;
  logic            cond_q, cond_d;
  logic            armed;
  logic            fl_fall, rs_rise, cn_rise;
  logic            go_fl, go_rs, go_cn;

  assign armed = warm_q[WARM-1];

  always_comb begin
    warm_d  = {warm_q[WARM-2:0], 1'b1};
    fl_fall = prev_q.fl & ~s_i.fl;
    rs_rise = ~prev_q.rs & s_i.rs;
    cn_rise = ~prev_q.cn & s_i.cn;
    go_fl   = fl_fall & s_i.rs & s_i.cn;
    go_rs   = rs_rise & ~s_i.fl & s_i.cn;
    go_cn   = cn_rise & ~s_i.fl & s_i.rs & cond_q;
    fire_o     = armed & ~busy_i & (go_fl | go_rs | go_cn);
    fire_clr_o = armed & ~busy_i & go_cn;
  end

  // Arming flag: set by a blocking level while clear is inactive, consumed by a clear-release fire.
  always_comb begin
    cond_d = cond_q;
    if (armed && s_i.cn && (s_i.fl || !s_i.rs)) cond_d = 1'b1;
    else if (fire_clr_o)                         cond_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= TRIG_SAFE;
      warm_q <= '0;
      cond_q <= 1'b0;
    end else begin
      prev_q <= s_i;
      if (!armed) warm_q <= warm_d;
      cond_q <= cond_d;
    end
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          clr_i,
  input  logic [CW-1:0] width_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d, load;
  logic          cnt_en;

  // The counter holds the cycles left after the current one; width 0 still gives one cycle.
  assign load = (width_i == '0) ? '0 : width_i - CW'(1);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      if (!clr_i || cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
    end else if (fire_i) begin
      busy_d = 1'b1;
      cnt_d  = load;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/os_channel.sv
module os_channel
  import oneshot_pkg::*;
#(
  parameter int CW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fl_i,
  input  logic          rs_i,
  input  logic          cn_i,
  input  logic [CW-1:0] width_i,
  output logic          pulse_o,
  output logic          pulse_n_o,
  output logic          busy_o,
  output logic          fire_o,
  output logic          fire_clr_o,
  output logic          cond_o,
  output logic          clr_s_o,
  output logic [CW-1:0] cnt_o
);
  trig_t raw, syn;

  assign raw = '{fl: fl_i, rs: rs_i, cn: cn_i};

  os_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  os_qual #(.STAGES(STAGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .s_i(syn), .busy_i(busy_o),
    .fire_o(fire_o), .fire_clr_o(fire_clr_o), .cond_o(cond_o)
  );

  os_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_o), .clr_i(syn.cn),
    .width_i(width_i), .busy_o(busy_o), .cnt_o(cnt_o)
  );

  // The synchronized clear masks the output in the same cycle it arrives.
  assign pulse_o   = busy_o & syn.cn;
  assign pulse_n_o = ~pulse_o;
  assign clr_s_o   = syn.cn;
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int NCH         = 2,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fall_trig_i,
  input  logic [NCH-1:0]    rise_trig_i,
  input  logic [NCH-1:0]    clr_n_i,
  input  logic [NCH*CW-1:0] width_i,
  output logic [NCH-1:0]    pulse_o,
  output logic [NCH-1:0]    pulse_n_o
);
  logic [NCH-1:0]    ch_busy, ch_fire, ch_fire_clr, ch_cond, ch_clr_s;
  logic [NCH*CW-1:0] ch_cnt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    os_channel #(.CW(CW), .STAGES(SYNC_STAGES)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fl_i      (fall_trig_i[i]),
      .rs_i      (rise_trig_i[i]),
      .cn_i      (clr_n_i[i]),
      .width_i   (width_i[i*CW +: CW]),
      .pulse_o   (pulse_o[i]),
      .pulse_n_o (pulse_n_o[i]),
      .busy_o    (ch_busy[i]),
      .fire_o    (ch_fire[i]),
      .fire_clr_o(ch_fire_clr[i]),
      .cond_o    (ch_cond[i]),
      .clr_s_o   (ch_clr_s[i]),
      .cnt_o     (ch_cnt[i*CW +: CW])
    );
  end
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*CW-1:0] width_i,
  input logic [NCH-1:0]    busy,
  input logic [NCH-1:0]    fire,
  input logic [NCH-1:0]    fire_clr,
  input logic [NCH-1:0]    cond,
  input logic [NCH-1:0]    clr_s,
  input logic [NCH*CW-1:0] cnt
);
  function automatic logic [CW-1:0] exp_load(input logic [CW-1:0] w);
    return (w == '0) ? '0 : w - CW'(1);
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> busy[g]); // R2

    AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] && !clr_s[g] |=> !busy[g]); // R5

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] && $past(busy[g]) |-> cnt[g*CW +: CW] == CW'($past(cnt[g*CW +: CW]) - CW'(1))); // R6

    AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[g]) |-> cnt[g*CW +: CW] == exp_load($past(width_i[g*CW +: CW]))); // R9

    AST_LATCH_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      fire_clr[g] |=> !cond[g]); // R8
  end
endmodule

bind dual_oneshot oneshot_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .width_i(width_i), .busy(ch_busy), .fire(ch_fire),
  .fire_clr(ch_fire_clr), .cond(ch_cond), .clr_s(ch_clr_s), .cnt(ch_cnt)
);

// File: tb/sim_dual_oneshot.sv
module sim_dual_oneshot;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    fa, rb, cn;
  logic [NCH*CW-1:0] wd;
  logic [NCH-1:0]    q, qn;

  always #4 clk = ~clk;

  dual_oneshot #(.NCH(NCH), .CW(CW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .fall_trig_i(fa), .rise_trig_i(rb),
    .clr_n_i(cn), .width_i(wd), .pulse_o(q), .pulse_n_o(qn)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // Reference model: input history per channel as {fall, rise, clear_n}.
  logic [2:0] hist [NCH][$];
  bit         m_busy [NCH];
  int         m_left [NCH];
  bit         m_cond [NCH];
  int         edges;

  task automatic chk(input bit ok, input string req, input int ch, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s ch%0d act=%0d exp=%0d t=%0t", req, ch, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0;
      for (int ch = 0; ch < NCH; ch++) begin
        hist[ch] = {3'b100, 3'b100, 3'b100};
        m_busy[ch] = 0;
        m_left[ch] = 0;
        m_cond[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        logic [2:0] s, p;
        bit armed, ga, gb, gc, was_busy;
        int w;
        s = hist[ch][1];
        p = hist[ch][0];
        armed = (edges >= 3);
        was_busy = m_busy[ch];
        ga = p[2] & ~s[2] & s[1] & s[0];
        gb = ~p[1] & s[1] & ~s[2] & s[0];
        gc = ~p[0] & s[0] & ~s[2] & s[1] & m_cond[ch];
        if (was_busy) begin
          if (!s[0] || m_left[ch] == 1) m_busy[ch] = 0;
          else m_left[ch] = m_left[ch] - 1;
        end else if (armed && (ga || gb || gc)) begin
          w = int'(wd[ch*CW +: CW]);
          m_busy[ch] = 1;
          m_left[ch] = (w == 0) ? 1 : w;
        end
        if (armed && s[0] && (s[2] || !s[1])) m_cond[ch] = 1;
        else if (armed && !was_busy && gc)   m_cond[ch] = 0;
        hist[ch].push_back({fa[ch], rb[ch], cn[ch]});
        void'(hist[ch].pop_front());
      end
      edges++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bit e;
        e = m_busy[ch] & hist[ch][1][0];
        chk(q[ch] === e, tag, ch, int'(q[ch]), int'(e));
        chk(qn[ch] === ~e, "R10", ch, int'(qn[ch]), int'(~e));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setin(input int ch, input bit a, input bit b, input bit c);
    fa[ch] = a;
    rb[ch] = b;
    cn[ch] = c;
  endtask

  task automatic setw(input int ch, input int w);
    wd[ch*CW +: CW] = CW'(w);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    finish_run();
  end

  initial begin
    fa = '1; rb = '0; cn = '1; wd = '0; rst_n = 1'b0;
    // R1: idle outputs during reset
    repeat (3) begin
      @(negedge clk);
      chk(q == '0, "R1", 0, int'(q), 0);
      chk(qn == '1, "R1", 0, int'(qn), 3);
    end
    rst_n = 1'b1;
    tag = "R1"; cyc(6);
    setw(0, 5); setw(1, 5);

    // R4: rising trigger blocked by high falling input
    tag = "R4"; setin(0, 1, 1, 1); cyc(8);
    // R2: falling trigger with rising input high
    tag = "R2"; setin(0, 0, 1, 1); cyc(10);
    setin(0, 1, 0, 1); cyc(5);
    // R4: falling trigger blocked by low rising input
    tag = "R4"; setin(0, 0, 0, 1); cyc(8);
    // R3: rising trigger with falling input low
    tag = "R3"; setin(0, 0, 1, 1); cyc(10);

    // R6: edges during a running pulse are ignored
    tag = "R6"; setw(0, 12); setin(0, 1, 0, 1); cyc(4);
    setin(0, 1, 1, 1); cyc(4);
    setin(0, 0, 1, 1); cyc(4);
    for (int i = 0; i < 3; i++) begin
      setin(0, 1, 0, 1); cyc(1);
      setin(0, 0, 1, 1); cyc(1);
    end
    cyc(15);

    // R9: width 0 and 1 give one cycle; width change mid-pulse ignored
    tag = "R9"; setin(0, 1, 0, 1); cyc(4);
    setw(0, 0); setin(0, 0, 0, 1); cyc(2);
    setin(0, 0, 1, 1); cyc(8);
    setw(0, 1); setin(0, 1, 1, 1); cyc(2);
    setin(0, 0, 1, 1); cyc(8);
    setw(0, 6); setin(0, 1, 1, 1); cyc(2);
    setin(0, 0, 1, 1); cyc(4);
    setw(0, 40); cyc(12);
    setw(0, 3); setin(0, 1, 1, 1); cyc(2);
    setin(0, 0, 1, 1); cyc(8);

    // R5: clear truncates, release with blocking input does not refire
    tag = "R5"; setw(0, 20); setin(0, 1, 1, 1); cyc(3);
    setin(0, 0, 1, 1); cyc(8);
    setin(0, 0, 1, 0); cyc(6);
    setin(0, 1, 0, 0); cyc(3);
    setin(0, 1, 0, 1); cyc(25);

    // R7: armed clear release fires
    tag = "R7"; setin(0, 1, 0, 0); cyc(3);
    setin(0, 0, 0, 0); cyc(3);
    setin(0, 0, 1, 0); cyc(3);
    setw(0, 8); setin(0, 0, 1, 1); cyc(14);
    // R8: second clear cycle without re-arming fires nothing
    tag = "R8"; setin(0, 0, 1, 0); cyc(4);
    setin(0, 0, 1, 1); cyc(10);
    // R7: blocking level while clear is low does not arm
    tag = "R7"; setin(0, 0, 1, 0); cyc(2);
    setin(0, 1, 1, 0); cyc(3);
    setin(0, 0, 1, 0); cyc(3);
    setin(0, 0, 1, 1); cyc(10);
    // R7: low rising input while clear is high arms, then release fires
    setin(0, 0, 0, 1); cyc(4);
    setin(0, 0, 0, 0); cyc(3);
    setin(0, 0, 1, 0); cyc(3);
    setin(0, 0, 1, 1); cyc(12);

    // R11: channels independent
    tag = "R11"; setw(0, 9); setw(1, 4);
    setin(0, 1, 0, 1); setin(1, 1, 0, 1); cyc(4);
    setin(0, 1, 1, 1); setin(1, 1, 1, 1); cyc(3);
    setin(0, 0, 1, 1); setin(1, 0, 1, 1); cyc(3);
    setin(1, 1, 1, 0); cyc(15);
    setin(1, 1, 0, 1); setin(0, 0, 0, 0); cyc(3);
    setin(1, 0, 0, 1); cyc(2);
    setin(1, 0, 1, 1); cyc(10);
    setin(0, 1, 0, 1); cyc(6);

    finish_run();
  end
endmodule